// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of maskable peripheral interrupt channels and a fixed group of non-maskable exception sources, picks one winner, and forms a 16-bit vector address from it. Two consumers are served by the same configuration. The main CPU sees a combinational pending flag and, on a one-cycle fetch strobe, receives a latched vector. A coprocessor receives its own winner over a valid/ready stream.

A small register bank holds an 8-bit vector base, which forms the upper byte of every vector except the reset ones. Each maskable channel has a 3-bit priority level and a routing bit. CPU-routed channels must rise above the CPU's current processing level before they are taken, so handlers can nest. Coprocessor-routed channels are not gated by that level or by the CPU mask bits.

The coprocessor stream follows the usual handshake. A vector is offered with `cop_valid` high and changes only after a cycle in which `cop_ready` is high. While `cop_ready` stays low, both the vector and the valid flag are held, even if the request that produced them has gone away.

Top module: `prio_vec_intc`

## Requirements
- R1: The configuration bank has the base register at address 0 (reset value 0xFF) and the config byte of channel i at address i+1 (reset value 0x01). In a config byte, bit 7 is the route (1 = coprocessor) and bits 2:0 are the level. `cfg_rdata` returns the addressed register combinationally, with the unused bits reading 0.
- R2: Channel 0 is the external pin request. Its route bit always reads 0, and it is never offered to the coprocessor.
- R3: The vector of maskable channel i is {base, 0xF2 - 2*i}.
- R4: A fetch that finds no winner, including when a request drops before the strobe, returns the spurious vector {base, 0x10}.
- R5: Non-maskable exceptions outrank every maskable channel. Among themselves they rank trap {base,F8}, software interrupt {base,F6}, X-pin {base,F4}, access violation 2/1/0 at {base,18}/{base,16}/{base,14}, and system call {base,12}, in that order.
- R6: A nonzero `rst_cause` outranks everything and selects a fixed vector that ignores the base: 1 gives 0xFFFE, 2 gives 0xFFFC, 3 gives 0xFFFA.
- R7: A maskable channel is eligible for the CPU only when it requests, is routed to the CPU, has a level greater than `cpu_ipl`, and `cpu_imask` is low. Level 0 therefore disables the channel.
- R8: Among eligible channels the highest level wins. On a tie, the lower index wins, which is the higher vector address.
- R9: `cpu_xmask` gates only the X-pin exception. `cpu_imask` gates none of the exceptions.
- R10: `cpu_vec` and `cpu_vec_lvl` load at a clock edge where `cpu_fetch` is high and hold otherwise; both reset to 0. `cpu_vec_lvl` is the winner's level for a maskable vector and `cpu_ipl` for any other vector.
- R11: `cpu_irq` is high in the same cycle whenever a reset cause, an unmasked exception, or an eligible CPU channel is present.
- R12: A coprocessor candidate is any requesting channel routed to the coprocessor with a nonzero level, regardless of `cpu_ipl`, `cpu_imask` and `cpu_xmask`. The winner is chosen as in R8 and registered into `cop_vec`/`cop_valid` whenever the output is empty or accepted.
- R13: While `cop_valid` is high and `cop_ready` is low, `cop_valid` and `cop_vec` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | CFG_AW | Config register address |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for cfg_addr |
| irq_req | input | NUM_CH | Maskable channel requests (bit 0 = pin request) |
| exc_trap | input | 1 | Unimplemented-opcode trap |
| exc_swi | input | 1 | Software interrupt / debug entry |
| exc_xirq | input | 1 | X-pin request |
| exc_acc | input | 3 | Access violation requests |
| exc_sys | input | 1 | System call request |
| rst_cause | input | 2 | Reset cause (0 = none) |
| cpu_imask | input | 1 | CPU I mask bit |
| cpu_xmask | input | 1 | CPU X mask bit |
| cpu_ipl | input | 3 | CPU current processing level |
| cpu_irq | output | 1 | CPU interrupt pending |
| cpu_fetch | input | 1 | One-cycle vector fetch strobe |
| cpu_vec | output | 16 | Latched CPU vector |
| cpu_vec_lvl | output | 3 | Processing level that goes with cpu_vec |
| cop_valid | output | 1 | Coprocessor vector valid |
| cop_ready | input | 1 | Coprocessor accepts the vector |
| cop_vec | output | 16 | Coprocessor vector |

## Verification
`cpu_irq` and `cfg_rdata` are combinational. The bench samples them one time unit after it drives new inputs on the falling edge. `cpu_vec` and `cpu_vec_lvl` are due one rising edge after the cycle in which `cpu_fetch` is high, so each fetch is raised on a falling edge and checked on the next falling edge. The coprocessor stream likewise moves one rising edge after its inputs change, and the bench checks it on the following falling edge, then again several cycles later while back-pressure is applied.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;
  localparam logic [7:0] OFS_SPUR = 8'h10;
  localparam logic [7:0] OFS_SYS  = 8'h12;
  localparam logic [7:0] OFS_ACC0 = 8'h14;
  localparam logic [7:0] OFS_CH0  = 8'hF2;
  localparam logic [7:0] OFS_XIRQ = 8'hF4;
  localparam logic [7:0] OFS_SWI  = 8'hF6;
  localparam logic [7:0] OFS_TRAP = 8'hF8;
  localparam int unsigned MAX_CH  = 109;

  // low byte of a maskable channel vector: channel 0 sits highest
  function automatic logic [7:0] ch_ofs(input int unsigned idx);
    return OFS_CH0 - 8'(2 * idx);
  endfunction
endpackage

// File: rtl/pvi_regs.sv
module pvi_regs #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned AW       = 4,
  parameter logic [7:0]  BASE_RST = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [7:0]             base,
  output logic [NUM_CH-1:0]      route,
  output logic [NUM_CH-1:0][2:0] lvl
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[6:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= BASE_RST;
      route <= '0;
      for (int i = 0; i < NUM_CH; i++) lvl[i] <= 3'd1;
    end else if (we) begin
      if (addr == '0) base <= wdata;
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == AW'(i + 1)) begin
          // the pin request channel may only serve the CPU
          route[i] <= (i == 0) ? 1'b0 : wdata[7];
          lvl[i]   <= wdata[2:0];
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == '0) rdata = base;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == AW'(i + 1)) rdata = {route[i], 4'b0000, lvl[i]};
  end
endmodule

// File: rtl/pvi_arb.sv
module pvi_arb #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      elig,
  input  logic [NUM_CH-1:0][2:0] lvl,
  output logic                   hit,
  output logic [IW-1:0]          idx,
  output logic [2:0]             win_lvl
);
  // scan from the top index down; ">=" lets the lower index take ties
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    win_lvl = 3'd0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i] && (lvl[i] >= win_lvl)) begin
        hit     = 1'b1;
        idx     = IW'(i);
        win_lvl = lvl[i];
      end
    end
  end

  for (genvar j = 0; j < NUM_CH; j++) begin : g_chk
    a_r8_no_higher_loser: assert property (@(posedge clk) disable iff (!rst_n)
      elig[j] |-> (hit && (lvl[j] <= win_lvl)));
    a_r8_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[j] && (lvl[j] == win_lvl)) |-> (int'(idx) <= j));
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import prio_vec_intc_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned CFG_AW   = $clog2(NUM_CH + 1),
  parameter logic [7:0]  BASE_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [NUM_CH-1:0] irq_req,
  input  logic              exc_trap,
  input  logic              exc_swi,
  input  logic              exc_xirq,
  input  logic [2:0]        exc_acc,
  input  logic              exc_sys,
  input  logic [1:0]        rst_cause,
  input  logic              cpu_imask,
  input  logic              cpu_xmask,
  input  logic [2:0]        cpu_ipl,
  output logic              cpu_irq,
  input  logic              cpu_fetch,
  output logic [15:0]       cpu_vec,
  output logic [2:0]        cpu_vec_lvl,
  output logic              cop_valid,
  input  logic              cop_ready,
  output logic [15:0]       cop_vec
);
  localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  initial begin
    if (NUM_CH < 1 || NUM_CH > MAX_CH) $error("NUM_CH out of range");
  end

  logic [7:0]             base;
  logic [NUM_CH-1:0]      route;
  logic [NUM_CH-1:0][2:0] lvl;

  pvi_regs #(.NUM_CH(NUM_CH), .AW(CFG_AW), .BASE_RST(BASE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .base(base), .route(route), .lvl(lvl)
  );

  logic [NUM_CH-1:0] elig_cpu, elig_cop;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      elig_cpu[i] = irq_req[i] && !route[i] && (lvl[i] > cpu_ipl) && !cpu_imask;
      elig_cop[i] = irq_req[i] && route[i] && (lvl[i] != 3'd0);
    end
  end

  logic          cpu_hit, cop_hit;
  logic [IW-1:0] cpu_idx, cop_idx;
  logic [2:0]    cpu_lvl, cop_lvl_unused;

  pvi_arb #(.NUM_CH(NUM_CH), .IW(IW)) u_arb_cpu (
    .clk(clk), .rst_n(rst_n), .elig(elig_cpu), .lvl(lvl),
    .hit(cpu_hit), .idx(cpu_idx), .win_lvl(cpu_lvl)
  );
  pvi_arb #(.NUM_CH(NUM_CH), .IW(IW)) u_arb_cop (
    .clk(clk), .rst_n(rst_n), .elig(elig_cop), .lvl(lvl),
    .hit(cop_hit), .idx(cop_idx), .win_lvl(cop_lvl_unused)
  );

  // fixed-order exception selection, above every maskable channel
  logic        exc_hit;
  logic [15:0] exc_vec;
  always_comb begin
    exc_hit = 1'b1;
    exc_vec = {base, OFS_SPUR};
    if (rst_cause != 2'd0)          exc_vec = {8'hFF, 8'hFE - {5'd0, rst_cause - 2'd1, 1'b0}};
    else if (exc_trap)              exc_vec = {base, OFS_TRAP};
    else if (exc_swi)               exc_vec = {base, OFS_SWI};
    else if (exc_xirq && !cpu_xmask) exc_vec = {base, OFS_XIRQ};
    else if (exc_acc[2])            exc_vec = {base, OFS_ACC0 + 8'd4};
    else if (exc_acc[1])            exc_vec = {base, OFS_ACC0 + 8'd2};
    else if (exc_acc[0])            exc_vec = {base, OFS_ACC0};
    else if (exc_sys)               exc_vec = {base, OFS_SYS};
    else                            exc_hit = 1'b0;
  end

  assign cpu_irq = exc_hit || cpu_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_vec     <= 16'h0000;
      cpu_vec_lvl <= 3'd0;
    end else if (cpu_fetch) begin
      if (exc_hit) begin
        cpu_vec     <= exc_vec;
        cpu_vec_lvl <= cpu_ipl;
      end else if (cpu_hit) begin
        cpu_vec     <= {base, ch_ofs(int'(cpu_idx))};
        cpu_vec_lvl <= cpu_lvl;
      end else begin
        cpu_vec     <= {base, OFS_SPUR};
        cpu_vec_lvl <= cpu_ipl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_valid <= 1'b0;
      cop_vec   <= 16'h0000;
    end else if (!cop_valid || cop_ready) begin
      cop_valid <= cop_hit;
      cop_vec   <= {base, ch_ofs(int'(cop_idx))};
    end
  end

  a_r13_cop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && !cop_ready) |=> (cop_valid && $stable(cop_vec)));
  a_r2_pin_never_cop: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid |-> (cop_vec[7:0] != OFS_CH0));
  a_r4_spurious_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch && !cpu_irq) |=> (cpu_vec == {$past(base), OFS_SPUR}));
  a_r10_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_fetch |=> ($stable(cpu_vec) && $stable(cpu_vec_lvl)));
  a_r6_reset_vec_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch && (rst_cause != 2'd0)) |=> (cpu_vec[15:8] == 8'hFF));
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int N = 8;
  localparam int AW = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [AW-1:0] cfg_addr = '0; logic [7:0] cfg_wdata = '0; logic [7:0] cfg_rdata;
  logic [N-1:0] irq_req = '0;
  logic exc_trap = 0, exc_swi = 0, exc_xirq = 0, exc_sys = 0; logic [2:0] exc_acc = '0;
  logic [1:0] rst_cause = '0;
  logic cpu_imask = 0, cpu_xmask = 0; logic [2:0] cpu_ipl = '0;
  logic cpu_irq, cpu_fetch = 0; logic [15:0] cpu_vec; logic [2:0] cpu_vec_lvl;
  logic cop_valid, cop_ready = 0; logic [15:0] cop_vec;

  int n_chk = 0, n_bad = 0;
  int blvl[N]; bit broute[N]; int bbase = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_intc #(.NUM_CH(N)) u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_req(irq_req), .exc_trap(exc_trap), .exc_swi(exc_swi),
    .exc_xirq(exc_xirq), .exc_acc(exc_acc), .exc_sys(exc_sys), .rst_cause(rst_cause),
    .cpu_imask(cpu_imask), .cpu_xmask(cpu_xmask), .cpu_ipl(cpu_ipl), .cpu_irq(cpu_irq),
    .cpu_fetch(cpu_fetch), .cpu_vec(cpu_vec), .cpu_vec_lvl(cpu_vec_lvl),
    .cop_valid(cop_valid), .cop_ready(cop_ready), .cop_vec(cop_vec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_ch(input int ch, input bit rt, input int lv);
    cfg_we = 1; cfg_addr = AW'(ch + 1); cfg_wdata = {rt, 4'b0000, 3'(lv)};
    @(negedge clk); cfg_we = 0;
    broute[ch] = (ch == 0) ? 1'b0 : rt; blvl[ch] = lv;
  endtask

  task automatic fetch();
    cpu_fetch = 1; @(negedge clk); cpu_fetch = 0;
  endtask

  function automatic void mdl(input logic [N-1:0] req, input int ipl, input bit im,
                              output bit hit, output int widx, output int wl);
    hit = 0; widx = 0; wl = 0;
    for (int i = 0; i < N; i++)
      if (req[i] && !broute[i] && blvl[i] > ipl && !im && blvl[i] > wl) begin
        hit = 1; widx = i; wl = blvl[i];
      end
  endfunction

  task automatic cpu_expect(input string req);
    bit h; int wi, wl, ev, el;
    mdl(irq_req, int'(cpu_ipl), cpu_imask, h, wi, wl);
    #1;
    check(cpu_irq == h, {req, " R11 pending"}, cpu_irq, h);
    fetch();
    ev = h ? (bbase * 256 + 'hF2 - 2 * wi) : (bbase * 256 + 'h10);
    el = h ? wl : int'(cpu_ipl);
    check(cpu_vec == 16'(ev), {req, " R3 vector"}, cpu_vec, ev);
    check(cpu_vec_lvl == 3'(el), {req, " R10 level"}, cpu_vec_lvl, el);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin blvl[i] = 1; broute[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset values, R10/R12/R11 reset state
    check(cfg_rdata == 8'hFF, "R1 base reset", cfg_rdata, 'hFF);
    cfg_addr = 4'd1; #1;
    check(cfg_rdata == 8'h01, "R1 channel reset", cfg_rdata, 1);
    check(cop_valid == 0, "R12 cop reset", cop_valid, 0);
    check(cpu_irq == 0, "R11 idle", cpu_irq, 0);
    check(cpu_vec == 0, "R10 vec reset", cpu_vec, 0);
    @(negedge clk);

    cfg_we = 1; cfg_addr = 0; cfg_wdata = 8'h40; @(negedge clk); cfg_we = 0; bbase = 'h40; #1;
    check(cfg_rdata == 8'h40, "R1 base write", cfg_rdata, 'h40);
    set_ch(0, 1, 7); cfg_addr = 4'd1; #1;
    check(cfg_rdata == 8'h07, "R2 pin route forced", cfg_rdata, 7);
    set_ch(3, 1, 5); cfg_addr = 4'd4; #1;
    check(cfg_rdata == 8'h85, "R1 channel write", cfg_rdata, 'h85);
    for (int i = 0; i < N; i++) set_ch(i, 0, 0);

    cpu_expect("R4 spurious");

    // R5 exception ranking sweep, with a live maskable channel underneath
    set_ch(5, 0, 7); irq_req = 8'h20;
    for (int m = 1; m < 128; m++) begin
      int top, ofs;
      {exc_trap, exc_swi, exc_xirq, exc_acc[2], exc_acc[1], exc_acc[0], exc_sys} = 7'(m);
      top = 0;
      for (int k = 0; k < 7; k++) if (m[k]) top = k;
      ofs = (top < 4) ? ('h12 + 2 * top) : ('hF4 + 2 * (top - 4));
      #1; check(cpu_irq == 1, "R5 pending", cpu_irq, 1);
      fetch();
      check(cpu_vec == 16'('h4000 + ofs), "R5 exception order", cpu_vec, 'h4000 + ofs);
    end
    {exc_trap, exc_swi, exc_xirq, exc_acc, exc_sys} = '0; irq_req = '0;

    // R9 mask bits
    cpu_xmask = 1; exc_xirq = 1; #1;
    check(cpu_irq == 0, "R9 xmask gates X pin", cpu_irq, 0);
    fetch();
    check(cpu_vec == 16'h4010, "R9 xmask spurious", cpu_vec, 'h4010);
    exc_xirq = 0; cpu_xmask = 0; cpu_imask = 1; exc_trap = 1; #1;
    check(cpu_irq == 1, "R9 imask leaves trap", cpu_irq, 1);
    fetch();
    check(cpu_vec == 16'h40F8, "R9 trap under imask", cpu_vec, 'h40F8);

    // R6 reset causes override trap and base
    for (int rc = 1; rc < 4; rc++) begin
      rst_cause = 2'(rc); fetch();
      check(cpu_vec == 16'('h10000 - 2 * rc), "R6 reset vector", cpu_vec, 'h10000 - 2 * rc);
    end
    rst_cause = 0; exc_trap = 0; cpu_imask = 0;

    // R7/R3/R10 single channel sweep over level and ipl
    for (int ch = 0; ch < N; ch++) begin
      for (int lv = 0; lv < 8; lv++) begin
        set_ch(ch, 0, lv); irq_req = '0; irq_req[ch] = 1'b1;
        for (int ip = 0; ip < 8; ip++) begin
          cpu_ipl = 3'(ip); cpu_expect("R7 single");
        end
        cpu_ipl = 0; cpu_imask = 1; cpu_expect("R7 imask");
        cpu_imask = 0;
      end
      set_ch(ch, 0, 0);
    end
    irq_req = '0;

    // R8 pairwise levels and ties
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (a != b)
          for (int la = 1; la < 8; la += 2)
            for (int lb = 1; lb < 8; lb++) begin
              set_ch(a, 0, la); set_ch(b, 0, lb);
              irq_req = '0; irq_req[a] = 1'b1; irq_req[b] = 1'b1;
              cpu_expect("R8 pair");
              irq_req = '0; set_ch(a, 0, 0); set_ch(b, 0, 0);
            end

    // R4 request drops before the strobe
    set_ch(2, 0, 3); irq_req = 8'h04; #1;
    check(cpu_irq == 1, "R11 pending ch2", cpu_irq, 1);
    @(negedge clk); irq_req = 0; fetch();
    check(cpu_vec == 16'h4010, "R4 dropped request", cpu_vec, 'h4010);
    repeat (3) @(negedge clk);
    check(cpu_vec == 16'h4010, "R10 hold without fetch", cpu_vec, 'h4010);

    // R12/R13 coprocessor stream
    set_ch(3, 1, 4); set_ch(6, 1, 6);
    cpu_imask = 1; cpu_ipl = 7; irq_req = 8'h48; #1;
    check(cpu_irq == 0, "R12 routed away from CPU", cpu_irq, 0);
    @(negedge clk);
    check(cop_valid == 1, "R12 cop valid", cop_valid, 1);
    check(cop_vec == 16'h40E6, "R12 cop winner", cop_vec, 'h40E6);
    irq_req = 0; repeat (3) @(negedge clk);
    check(cop_valid == 1, "R13 held valid", cop_valid, 1);
    check(cop_vec == 16'h40E6, "R13 held vector", cop_vec, 'h40E6);
    irq_req = 8'h08; cop_ready = 1; @(negedge clk);
    check(cop_vec == 16'h40EC, "R12 next after accept", cop_vec, 'h40EC);
    irq_req = 0; @(negedge clk);
    check(cop_valid == 0, "R12 empty after accept", cop_valid, 0);

    // R2 pin channel never reaches the coprocessor
    cpu_imask = 0; cpu_ipl = 0; set_ch(0, 1, 7); irq_req = 8'h01; #1;
    check(cpu_irq == 1, "R2 pin goes to CPU", cpu_irq, 1);
    @(negedge clk);
    check(cop_valid == 0, "R2 pin not on cop", cop_valid, 0);
    irq_req = 0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule